// File: doc/BRIEF.md
# Floating-Point Exception Precedence Resolver

This block sits beside a floating-point arithmetic unit. It collects the exception conditions raised by one operation and resolves them in a fixed order of precedence. Each exception class has its own mask bit. From these inputs the block decides which status flags to record, whether a default value replaces the computed result, whether the destination write may go ahead, and whether a fault must be signalled.

Resolution takes two phases. In the operand phase (`pre_valid`), conditions found on the operands are ranked before any result exists. If that phase ends the operation, either because a fault suppresses it or because a default value is chosen, the block reports at once. Otherwise the block waits for the result phase (`post_valid`), where overflow, underflow and inexact are resolved against the true result. Status flags are sticky. They are cleared only by `clear_flags`.

The controller has two states. ST_IDLE accepts an operand-phase pulse. ST_AWAIT holds while the arithmetic runs and accepts a result-phase pulse. The transition PROCEED (ST_IDLE to ST_AWAIT) is taken when the operand phase is clean or holds only a masked denormal. The transition FINISH (ST_AWAIT to ST_IDLE) is taken on `post_valid`. When ST_IDLE resolves the operation in the operand phase, it stays in ST_IDLE through the transition SETTLE.

Top module: `fpx_resolver`

## Requirements
- R1: After reset, `flags`, `fault`, `res_valid`, `commit` and `inv_code` are all zero and the controller waits in ST_IDLE.
- R2: The operand-phase invalid causes are `pre_cond[7]` stack underflow, `[6]` stack overflow, `[5]` unsupported format and `[4]` signaling NaN, ranked in that order. The highest one present sets flag bit 0 (invalid) and is reported on `inv_code` as 1, 2, 3 or 4 respectively. `inv_code` is 5 for any other invalid cause (`pre_cond[2]`) and 0 when no invalid cause is present.
- R3: A masked rank-one invalid (`exc_mask[0]`=1) gives `res_sel`=01 (real indefinite) with `commit`=1. It records only the invalid flag, even when divide-by-zero (`pre_cond[1]`) is present as well.
- R4: A quiet NaN operand (`pre_cond[3]`) with no rank-one cause raises no flag and no fault. It gives `res_sel`=10 with `commit`=1 and suppresses divide-by-zero, denormal and every result-phase condition.
- R5: At rank three, the other invalid cause and divide-by-zero both set their flags (bit 0, bit 1). When masked, the other invalid selects 01 and a lone divide-by-zero selects 00, each with `commit`=1. Denormal (bit 2) is suppressed at this rank.
- R6: An unmasked operand-phase exception gives `fault`=1, `res_sel`=11 and `commit`=0, and the block does not wait for a result phase.
- R7: A clean operand phase, or one holding only a masked denormal, moves to ST_AWAIT. The result phase then sets overflow (`post_cond[2]`, flag 3), underflow (`[1]`, flag 4) and inexact (`[0]`, flag 5) together with any denormal flag already raised.
- R8: In the result phase, an unmasked overflow or underflow gives `fault`=1 with `res_sel`=11 and no commit. An unmasked inexact alone gives `fault`=1 with `res_sel`=00 and `commit`=1.
- R9: Flags are sticky: new bits are OR-ed in and only `clear_flags` removes them. Bits raised in the same cycle as a clear survive.
- R10: `res_valid`, `fault`, `res_sel`, `commit` and `inv_code` are registered. They appear for exactly one cycle, one clock after the phase pulse that resolved the operation.
- R11: `post_valid` in ST_IDLE and `pre_valid` in ST_AWAIT are ignored: they change no flag and produce no `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_flags | input | 1 | Clears the sticky flags |
| pre_valid | input | 1 | Operand-phase conditions are valid |
| pre_cond | input | 8 | Operand conditions: [7] stack underflow, [6] stack overflow, [5] unsupported format, [4] signaling NaN, [3] quiet NaN, [2] other invalid, [1] divide-by-zero, [0] denormal |
| post_valid | input | 1 | Result-phase conditions are valid |
| post_cond | input | 3 | Result conditions: [2] overflow, [1] underflow, [0] inexact |
| exc_mask | input | 6 | Mask per flag (1 = masked): [0] invalid, [1] zero-divide, [2] denormal, [3] overflow, [4] underflow, [5] inexact |
| res_valid | output | 1 | One-cycle pulse: resolution outputs are valid |
| res_sel | output | 2 | 00 computed, 01 real indefinite, 10 propagated quiet NaN, 11 no write |
| commit | output | 1 | Destination write may proceed |
| fault | output | 1 | Fault request for an unmasked exception |
| inv_code | output | 3 | Invalid cause code (see R2) |
| flags | output | 6 | Sticky status flags, same bit order as `exc_mask` |

## Verification
The bench targets combinations in which the ranking decides the outcome. A signaling NaN divided by zero must flag only invalid; a design that also flagged divide-by-zero would fail. A quiet NaN divided by zero with divide-by-zero unmasked must still pass the NaN through without a fault; a design that let divide-by-zero through would fault. A masked denormal followed by result-phase overflow must leave both flags set; a design that ended the operation at the denormal would lose the overflow. The bench also covers a clear arriving together with new flag bits, and phase pulses given in the wrong state, where a careless controller would record a stale condition.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int NFLAGS   = 6;
    localparam int NPRE     = 8;
    localparam int NPOST    = 3;
    localparam int CODE_W   = 3;

    localparam int F_IE = 0;
    localparam int F_ZE = 1;
    localparam int F_DE = 2;
    localparam int F_OE = 3;
    localparam int F_UE = 4;
    localparam int F_PE = 5;

    typedef enum logic [1:0] {
        SEL_COMPUTED = 2'b00,
        SEL_INDEF    = 2'b01,
        SEL_QNAN     = 2'b10,
        SEL_NOWRITE  = 2'b11
    } res_sel_e;

    typedef enum logic [CODE_W-1:0] {
        CODE_NONE      = 3'd0,
        CODE_STK_UNDER = 3'd1,
        CODE_STK_OVER  = 3'd2,
        CODE_UNSUP     = 3'd3,
        CODE_SNAN      = 3'd4,
        CODE_OTHER     = 3'd5
    } inv_code_e;

    typedef struct packed {
        logic stk_under;
        logic stk_over;
        logic unsup;
        logic snan;
        logic qnan;
        logic inv_other;
        logic zdiv;
        logic denorm;
    } pre_cond_t;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic inx;
    } post_cond_t;

    typedef struct packed {
        logic [NFLAGS-1:0] raise;
        logic              fault;
        res_sel_e          sel;
        inv_code_e         code;
        logic              proceed;
    } verdict_t;

endpackage

// File: rtl/fpx_pre_rank.sv
module fpx_pre_rank
    import fpx_pkg::*;
(
    input  pre_cond_t  cond,
    input  logic [2:0] mask_lo,
    output verdict_t   verdict
);

    logic rank_one;
    logic rank_three;
    logic [NFLAGS-1:0] r3_bits;

    assign rank_one   = cond.stk_under | cond.stk_over | cond.unsup | cond.snan;
    assign rank_three = cond.inv_other | cond.zdiv;

    always_comb begin
        r3_bits        = '0;
        r3_bits[F_IE]  = cond.inv_other;
        r3_bits[F_ZE]  = cond.zdiv;
    end

    always_comb begin
        verdict         = '0;
        verdict.sel     = SEL_COMPUTED;
        verdict.code    = CODE_NONE;
        if (cond.stk_under)      verdict.code = CODE_STK_UNDER;
        else if (cond.stk_over)  verdict.code = CODE_STK_OVER;
        else if (cond.unsup)     verdict.code = CODE_UNSUP;
        else if (cond.snan)      verdict.code = CODE_SNAN;
        else if (!cond.qnan && cond.inv_other) verdict.code = CODE_OTHER;

        if (rank_one) begin
            verdict.raise[F_IE] = 1'b1;
            verdict.fault       = !mask_lo[F_IE];
            verdict.sel         = mask_lo[F_IE] ? SEL_INDEF : SEL_NOWRITE;
        end else if (cond.qnan) begin
            verdict.sel         = SEL_QNAN;
        end else if (rank_three) begin
            verdict.raise = r3_bits;
            verdict.fault = |(r3_bits[2:0] & ~mask_lo);
            if (verdict.fault)        verdict.sel = SEL_NOWRITE;
            else if (cond.inv_other)  verdict.sel = SEL_INDEF;
            else                      verdict.sel = SEL_COMPUTED;
        end else if (cond.denorm) begin
            verdict.raise[F_DE] = 1'b1;
            verdict.fault       = !mask_lo[F_DE];
            verdict.sel         = mask_lo[F_DE] ? SEL_COMPUTED : SEL_NOWRITE;
            verdict.proceed     = mask_lo[F_DE];
        end else begin
            verdict.proceed     = 1'b1;
        end
    end

endmodule

// File: rtl/fpx_post_rank.sv
module fpx_post_rank
    import fpx_pkg::*;
(
    input  post_cond_t cond,
    input  logic [2:0] mask_hi,
    output verdict_t   verdict
);

    logic [NPOST-1:0] hit;
    logic             blocking;

    assign hit      = {cond.inx, cond.unf, cond.ovf} & ~mask_hi;
    assign blocking = hit[0] | hit[1];

    always_comb begin
        verdict             = '0;
        verdict.code        = CODE_NONE;
        verdict.raise[F_OE] = cond.ovf;
        verdict.raise[F_UE] = cond.unf;
        verdict.raise[F_PE] = cond.inx;
        verdict.fault       = |hit;
        verdict.sel         = blocking ? SEL_NOWRITE : SEL_COMPUTED;
    end

endmodule

// File: rtl/fpx_resolver.sv
module fpx_resolver
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_flags,
    input  logic              pre_valid,
    input  logic [NPRE-1:0]   pre_cond,
    input  logic              post_valid,
    input  logic [NPOST-1:0]  post_cond,
    input  logic [NFLAGS-1:0] exc_mask,
    output logic              res_valid,
    output logic [1:0]        res_sel,
    output logic              commit,
    output logic              fault,
    output logic [CODE_W-1:0] inv_code,
    output logic [NFLAGS-1:0] flags
);

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_AWAIT = 1'b1
    } state_e;

    state_e    state, state_d;
    verdict_t  pre_v, post_v;
    logic      awaiting;
    logic      take_pre, take_post;

    logic              rv_d, fault_d, commit_d;
    res_sel_e          sel_d, sel_q;
    inv_code_e         code_d, code_q;
    logic [NFLAGS-1:0] raise_d, flags_q;
    logic              rv_q, fault_q, commit_q;

    fpx_pre_rank u_pre (
        .cond    (pre_cond_t'(pre_cond)),
        .mask_lo (exc_mask[2:0]),
        .verdict (pre_v)
    );

    fpx_post_rank u_post (
        .cond    (post_cond_t'(post_cond)),
        .mask_hi (exc_mask[5:3]),
        .verdict (post_v)
    );

    assign awaiting  = (state == ST_AWAIT);
    assign take_pre  = pre_valid && !awaiting;
    assign take_post = post_valid && awaiting;

    // next state: PROCEED, SETTLE, FINISH
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  if (take_pre && pre_v.proceed) state_d = ST_AWAIT;
            ST_AWAIT: if (take_post)                 state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        rv_d    = 1'b0;
        fault_d = 1'b0;
        sel_d   = SEL_COMPUTED;
        code_d  = CODE_NONE;
        raise_d = '0;
        unique case (state)
            ST_IDLE: begin
                if (take_pre) begin
                    raise_d = pre_v.raise;
                    if (!pre_v.proceed) begin
                        rv_d    = 1'b1;
                        fault_d = pre_v.fault;
                        sel_d   = pre_v.sel;
                        code_d  = pre_v.code;
                    end
                end
            end
            ST_AWAIT: begin
                if (take_post) begin
                    raise_d = post_v.raise;
                    rv_d    = 1'b1;
                    fault_d = post_v.fault;
                    sel_d   = post_v.sel;
                end
            end
            default: ;
        endcase
        commit_d = rv_d && (sel_d != SEL_NOWRITE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q     <= 1'b0;
            fault_q  <= 1'b0;
            commit_q <= 1'b0;
            sel_q    <= SEL_COMPUTED;
            code_q   <= CODE_NONE;
            flags_q  <= '0;
        end else begin
            rv_q     <= rv_d;
            fault_q  <= fault_d;
            commit_q <= commit_d;
            sel_q    <= sel_d;
            code_q   <= code_d;
            flags_q  <= (clear_flags ? '0 : flags_q) | raise_d;
        end
    end

    assign res_valid = rv_q;
    assign fault     = fault_q;
    assign commit    = commit_q;
    assign res_sel   = sel_q;
    assign inv_code  = code_q;
    assign flags     = flags_q;

endmodule

// File: rtl/fpx_resolver_chk.sv
module fpx_resolver_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       clear_flags,
    input logic       pre_valid,
    input logic [7:0] pre_cond,
    input logic       post_valid,
    input logic [5:0] exc_mask,
    input logic       res_valid,
    input logic [1:0] res_sel,
    input logic       commit,
    input logic       fault,
    input logic [5:0] flags
);

    // R6
    unmasked_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pre_valid && pre_cond[7] && !exc_mask[0])
        |=> (fault && res_sel == 2'b11 && !commit));

    // R4
    qnan_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pre_valid && pre_cond[7:3] == 5'b00001)
        |=> (res_sel == 2'b10 && commit && !fault));

    // R9
    sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_flags |=> ((flags & $past(flags)) == $past(flags)));

    // R8
    commit_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (res_valid && res_sel != 2'b11));

    // R10
    fault_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> res_valid);

    // R11
    idle_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && post_valid && !pre_valid) |=> !res_valid);

endmodule

bind fpx_resolver fpx_resolver_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (awaiting),
    .clear_flags (clear_flags),
    .pre_valid   (pre_valid),
    .pre_cond    (pre_cond),
    .post_valid  (post_valid),
    .exc_mask    (exc_mask),
    .res_valid   (res_valid),
    .res_sel     (res_sel),
    .commit      (commit),
    .fault       (fault),
    .flags       (flags)
);

// File: tb/fpx_resolver_bench.sv
module fpx_resolver_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_flags = 1'b0;
    logic       pre_valid = 1'b0;
    logic [7:0] pre_cond = '0;
    logic       post_valid = 1'b0;
    logic [2:0] post_cond = '0;
    logic [5:0] exc_mask = 6'h3F;
    logic       res_valid, commit, fault;
    logic [1:0] res_sel;
    logic [2:0] inv_code;
    logic [5:0] flags;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fpx_resolver u_fpx_resolver (
        .clk(clk), .rst_n(rst_n), .clear_flags(clear_flags),
        .pre_valid(pre_valid), .pre_cond(pre_cond),
        .post_valid(post_valid), .post_cond(post_cond),
        .exc_mask(exc_mask), .res_valid(res_valid), .res_sel(res_sel),
        .commit(commit), .fault(fault), .inv_code(inv_code), .flags(flags)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [7:0] pre;
        logic       post_en;
        logic [2:0] post;
        logic [5:0] mask;
        logic       e_fault;
        logic [1:0] e_sel;
        logic       e_commit;
        logic [2:0] e_code;
        logic [5:0] e_flags;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        {4'd7, 8'b00000000, 1'b1, 3'b000, 6'b111111, 1'b0, 2'b00, 1'b1, 3'd0, 6'b000000}, // R7 clean
        {4'd3, 8'b00010010, 1'b0, 3'b000, 6'b111111, 1'b0, 2'b01, 1'b1, 3'd4, 6'b000001}, // R3 snan/0
        {4'd6, 8'b00010010, 1'b0, 3'b000, 6'b111110, 1'b1, 2'b11, 1'b0, 3'd4, 6'b000001}, // R6
        {4'd4, 8'b00001010, 1'b0, 3'b000, 6'b111101, 1'b0, 2'b10, 1'b1, 3'd0, 6'b000000}, // R4 qnan/0
        {4'd2, 8'b11010000, 1'b0, 3'b000, 6'b111111, 1'b0, 2'b01, 1'b1, 3'd1, 6'b000001}, // R2
        {4'd2, 8'b01100000, 1'b0, 3'b000, 6'b111111, 1'b0, 2'b01, 1'b1, 3'd2, 6'b000001}, // R2
        {4'd2, 8'b00111000, 1'b0, 3'b000, 6'b111111, 1'b0, 2'b01, 1'b1, 3'd3, 6'b000001}, // R2
        {4'd5, 8'b00000110, 1'b0, 3'b000, 6'b111111, 1'b0, 2'b01, 1'b1, 3'd5, 6'b000011}, // R5
        {4'd5, 8'b00000010, 1'b0, 3'b000, 6'b111111, 1'b0, 2'b00, 1'b1, 3'd0, 6'b000010}, // R5
        {4'd6, 8'b00000010, 1'b0, 3'b000, 6'b111101, 1'b1, 2'b11, 1'b0, 3'd0, 6'b000010}, // R6
        {4'd5, 8'b00000011, 1'b0, 3'b000, 6'b111111, 1'b0, 2'b00, 1'b1, 3'd0, 6'b000010}, // R5 DE suppressed
        {4'd6, 8'b00000001, 1'b0, 3'b000, 6'b111011, 1'b1, 2'b11, 1'b0, 3'd0, 6'b000100}, // R6 DE
        {4'd7, 8'b00000001, 1'b1, 3'b101, 6'b111111, 1'b0, 2'b00, 1'b1, 3'd0, 6'b101100}, // R7 DE+OE+PE
        {4'd8, 8'b00000001, 1'b1, 3'b101, 6'b110111, 1'b1, 2'b11, 1'b0, 3'd0, 6'b101100}, // R8 OE
        {4'd8, 8'b00000000, 1'b1, 3'b001, 6'b011111, 1'b1, 2'b00, 1'b1, 3'd0, 6'b100000}, // R8 PE
        {4'd7, 8'b00000000, 1'b1, 3'b011, 6'b111111, 1'b0, 2'b00, 1'b1, 3'd0, 6'b110000}, // R7 UE+PE
        {4'd8, 8'b00000000, 1'b1, 3'b010, 6'b101111, 1'b1, 2'b11, 1'b0, 3'd0, 6'b010000}  // R8 UE
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] outs();
        return {17'd0, res_valid, fault, res_sel, commit, inv_code, flags};
    endfunction

    function automatic logic [31:0] want(input logic f, input logic [1:0] s,
                                         input logic c, input logic [2:0] k,
                                         input logic [5:0] fl);
        return {17'd0, 1'b1, f, s, c, k, fl};
    endfunction

    task automatic pulse_clear();
        clear_flags = 1'b1;
        @(negedge clk);
        clear_flags = 1'b0;
    endtask

    task automatic pre_pulse(input logic [7:0] c, input logic [5:0] m);
        pre_cond = c; exc_mask = m; pre_valid = 1'b1;
        @(negedge clk);
        pre_valid = 1'b0;
    endtask

    task automatic post_pulse(input logic [2:0] c);
        post_cond = c; post_valid = 1'b1;
        @(negedge clk);
        post_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {27'd0, res_valid, fault, commit, inv_code == 3'd0, flags == 6'd0},
              {27'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {26'd0, flags}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            pulse_clear();
            pre_pulse(VECS[i].pre, VECS[i].mask);
            if (VECS[i].post_en) begin
                check("R7", {31'd0, res_valid}, 32'd0);
                post_pulse(VECS[i].post);
            end
            check($sformatf("R%0d vec%0d", VECS[i].req, i), outs(),
                  want(VECS[i].e_fault, VECS[i].e_sel, VECS[i].e_commit,
                       VECS[i].e_code, VECS[i].e_flags));
        end

        // R10 result pulse lasts one cycle
        @(negedge clk);
        check("R10", {31'd0, res_valid}, 32'd0);

        // R9 sticky accumulation over two operations
        pulse_clear();
        pre_pulse(8'b00000010, 6'h3F);
        pre_pulse(8'b00000000, 6'h3F);
        post_pulse(3'b001);
        check("R9", {26'd0, flags}, {26'd0, 6'b100010});
        // R9 clear together with new bits: new bits survive
        clear_flags = 1'b1;
        pre_pulse(8'b00010000, 6'h3F);
        clear_flags = 1'b0;
        check("R9", {26'd0, flags}, {26'd0, 6'b000001});
        pulse_clear();
        check("R9", {26'd0, flags}, 32'd0);

        // R11 post pulse in idle ignored
        post_pulse(3'b111);
        check("R11", {25'd0, res_valid, flags}, 32'd0);
        // R11 pre pulse while awaiting result ignored
        pre_pulse(8'b00000000, 6'h3F);
        pre_pulse(8'b00010010, 6'h3F);
        check("R11", {25'd0, res_valid, flags}, 32'd0);
        post_pulse(3'b000);
        check("R11", outs(), want(1'b0, 2'b00, 1'b1, 3'd0, 6'b000000));

        // R10 latency: nothing before the edge, result right after it
        pre_cond = 8'b00000010; exc_mask = 6'b111101; pre_valid = 1'b1;
        @(posedge clk);
        #1;
        pre_valid = 1'b0;
        check("R10", {30'd0, res_valid, fault}, {30'd0, 1'b1, 1'b1});

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule